// File: doc/BRIEF.md
# Replayable Packet Descriptor Manager

This block keeps the per-channel bookkeeping for packets that sit in a shared buffer and may be sent more than once. For every channel it holds a small ring of descriptors (start address and byte length), a count of stored packets and a read position measured from the oldest stored packet. A write-side strobe appends a descriptor when a packet has been fully committed to the buffer, and a read-side strobe reports that the packet currently being sent has ended. The block does not hold packet data. It only hands out the descriptor that the data path should read next.

A scheduler picks the channel to serve through a valid/ready handshake. If that channel has a stored packet that has not yet been scheduled, the block acknowledges and presents its descriptor. Sent packets stay stored. A management port removes the oldest packets (flush) or moves the read position back or forward (rewind), both through a valid/ready handshake. A rewind aimed at the channel whose packet is in flight waits until that packet ends. A query port returns the count and read position of any channel one cycle after the request, and it can be pipelined every cycle.

Top module: `pkt_replay_mgr`

## Requirements
- R1: A cycle with `wr_commit` high appends (`wr_addr`, `wr_len`) as the newest descriptor of channel `wr_ch`, and that channel's count rises by one at the next clock edge. A commit to a channel already holding `DEPTH` packets is ignored and the stored count is left unchanged.
- R2: `rd_avail[c]` is high exactly while channel c holds at least one packet.
- R3: A channel number placed on `qry_ch` in one cycle gives, in the next cycle, that number on `qry_ch_echo`, its stored count on `qry_cnt` and its read position (0 = oldest) on `qry_pos`. A new query may be issued every cycle.
- R4: `sch_ready` rises only in the cycle after `sch_valid` was high and lasts one cycle. The channel is accepted in the cycle where both are high. `sch_ready` stays low while a packet is in flight, and it is never high together with `cmd_ready`.
- R5: Exactly two cycles after acceptance, `sch_ack` pulses if the channel's read position is below its count. In that cycle `out_ch`, `out_addr` and `out_len` give the descriptor at the read position, which then advances by one. If the position is not below the count, the request is dropped with no acknowledge, so scheduling one packet twice gives one acknowledge.
- R6: An acknowledged packet stays stored and counted. It is in flight until a `rd_done` pulse, and only a flush removes it.
- R7: A flush with index N (`cmd_flush`=1) discards the N oldest packets of `cmd_ch`. The count drops by N and the read position drops by N, with a floor of 0.
- R8: A rewind with index N (`cmd_rewind`=1) sets the read position of `cmd_ch` to N, so the next packet scheduled is the one N places after the oldest.
- R9: With both flags set, the N oldest packets are discarded, and the packet that was at position N becomes the next one read (read position 0).
- R10: `cmd_ready` rises only in the cycle after `cmd_valid` was high and lasts one cycle. A command runs only in the cycle where both are high, and the inputs are held until then.
- R11: A command with the rewind flag on the channel that has a packet in flight keeps `cmd_ready` low until the cycle after that packet's `rd_done`.
- R12: These commands are illegal: flush with N = 0, flush with N above the count, flush that would remove the in-flight packet (N at or above the read position on that channel), rewind with N at or above the count, and any command to a channel number of `NUM_CH` or more. An illegal command is handshaken but not applied, and `cmd_err` pulses in the cycle after the handshake.
- R13: A command with neither flag set is handshaken, has no effect, and raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_commit | input | 1 | Packet committed strobe |
| wr_ch | input | CH_W | Channel of committed packet |
| wr_addr | input | ADDR_W | Start address of committed packet |
| wr_len | input | LEN_W | Byte length of committed packet |
| rd_done | input | 1 | In-flight packet has ended |
| sch_valid | input | 1 | Scheduler request valid |
| sch_ch | input | CH_W | Channel to read next |
| sch_ready | output | 1 | Scheduler request accepted |
| sch_ack | output | 1 | Descriptor issued for the accepted channel |
| out_ch | output | CH_W | Channel of issued descriptor |
| out_addr | output | ADDR_W | Start address of issued descriptor |
| out_len | output | LEN_W | Byte length of issued descriptor |
| rd_avail | output | NUM_CH | Per-channel packet-stored flags |
| cmd_valid | input | 1 | Management command valid |
| cmd_ch | input | CH_W | Command target channel |
| cmd_idx | input | CNT_W | Command index N |
| cmd_flush | input | 1 | Flush flag |
| cmd_rewind | input | 1 | Rewind flag |
| cmd_ready | output | 1 | Command accepted |
| cmd_err | output | 1 | Illegal command pulse |
| qry_ch | input | CH_W | Query channel |
| qry_ch_echo | output | CH_W | Channel the query result belongs to |
| qry_cnt | output | CNT_W | Stored packet count |
| qry_pos | output | CNT_W | Read position from oldest |

## Verification
A wrong count appears on `rd_avail` in the cycle after the edge that corrupted it, and on `qry_cnt` one cycle after a query. A wrong head pointer or read position does not affect any flag. It shows only in the descriptor issued two cycles after the next scheduler acceptance, or on `qry_pos`. For this reason the bench follows every command with a query, and it replays and drains rings after flushes to compare the addresses and lengths of the packets issued. Mistakes in legality or deferral show in the cycle after the handshake, as a wrong `cmd_err`, or as `cmd_ready` rising while a packet is still in flight.

// File: rtl/pkq_pkg.sv
package pkq_pkg;

   // Management operation encoded as {rewind, flush}
   typedef enum logic [1:0] {
      OP_NONE   = 2'b00,
      OP_FLUSH  = 2'b01,
      OP_REWIND = 2'b10,
      OP_BOTH   = 2'b11
   } pkq_op_e;

   function automatic int bits_for(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/pkq_ring.sv
// One channel: descriptor ring with head pointer, count and read position.
module pkq_ring #(
   parameter int DEPTH  = 8,
   parameter int DESC_W = 26,
   parameter int PTR_W  = 3,
   parameter int CNT_W  = 4
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [DESC_W-1:0] push_desc,
   input  logic              adv,
   input  logic              drop,
   input  logic              rewind,
   input  logic [CNT_W-1:0]  amount,
   output logic [CNT_W-1:0]  count,
   output logic [CNT_W-1:0]  pos,
   output logic [DESC_W-1:0] next_desc
);

   logic [DESC_W-1:0] store [DEPTH];
   logic [PTR_W-1:0]  head;
   logic [PTR_W-1:0]  tail;
   logic              push_ok;
   logic [CNT_W-1:0]  pos_base;
   logic [CNT_W-1:0]  pos_nx;
   logic [CNT_W-1:0]  count_nx;
   logic [PTR_W-1:0]  head_nx;

   assign push_ok = push && (count != CNT_W'(DEPTH));
   assign tail    = head + count[PTR_W-1:0];

   always_comb begin
      pos_base = rewind ? amount : (pos + CNT_W'(adv));
      pos_nx   = pos_base;
      head_nx  = head;
      count_nx = count + CNT_W'(push_ok);
      if (drop) begin
         pos_nx   = (pos_base >= amount) ? (pos_base - amount) : '0;
         head_nx  = head + amount[PTR_W-1:0];
         count_nx = count + CNT_W'(push_ok) - amount;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head  <= '0;
         count <= '0;
         pos   <= '0;
      end else begin
         head  <= head_nx;
         count <= count_nx;
         pos   <= pos_nx;
      end
   end

   always_ff @(posedge clk) begin
      if (push_ok) store[tail] <= push_desc;
   end

   assign next_desc = store[head + pos[PTR_W-1:0]];

endmodule

// File: rtl/pkq_sched.sv
// Scheduler handshake, two-stage issue pipeline and in-flight tracking.
module pkq_sched #(
   parameter int NUM_CH = 4,
   parameter int CH_W   = 2,
   parameter int CNT_W  = 4,
   parameter int DESC_W = 26
)(
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           sch_valid,
   input  logic [CH_W-1:0]                sch_ch,
   input  logic                           block_i,
   input  logic                           done_i,
   input  logic [NUM_CH-1:0][CNT_W-1:0]   cnt_all,
   input  logic [NUM_CH-1:0][CNT_W-1:0]   pos_all,
   input  logic [NUM_CH-1:0][DESC_W-1:0]  desc_all,
   output logic                           sch_ready,
   output logic                           sch_ack,
   output logic [CH_W-1:0]                out_ch,
   output logic [DESC_W-1:0]              out_desc,
   output logic [NUM_CH-1:0]              adv,
   output logic                           busy,
   output logic [CH_W-1:0]                cur_ch,
   output logic                           s1_v,
   output logic                           sch_hs
);

   logic [CH_W-1:0] s1_ch;
   logic            s1_hit;
   logic            rdy_nxt;

   assign sch_hs  = sch_valid && sch_ready;
   assign rdy_nxt = sch_valid && !sch_ready && !busy && !s1_v && !block_i;

   always_comb begin
      s1_hit = 1'b0;
      if (s1_v && (int'(s1_ch) < NUM_CH))
         s1_hit = pos_all[s1_ch] < cnt_all[s1_ch];
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_adv
      assign adv[c] = s1_hit && (s1_ch == CH_W'(c));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sch_ready <= 1'b0;
         s1_v      <= 1'b0;
         s1_ch     <= '0;
         sch_ack   <= 1'b0;
         busy      <= 1'b0;
         cur_ch    <= '0;
         out_ch    <= '0;
         out_desc  <= '0;
      end else begin
         sch_ready <= rdy_nxt;
         s1_v      <= sch_hs;
         if (sch_hs) s1_ch <= sch_ch;
         sch_ack   <= s1_hit;
         if (s1_hit) begin
            busy     <= 1'b1;
            cur_ch   <= s1_ch;
            out_ch   <= s1_ch;
            out_desc <= desc_all[s1_ch];
         end else if (done_i) begin
            busy <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/pkq_cmd.sv
// Flush / rewind command handshake, deferral and legality.
module pkq_cmd
   import pkq_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int CH_W   = 2,
   parameter int CNT_W  = 4
)(
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         cmd_valid,
   input  logic [CH_W-1:0]              cmd_ch,
   input  logic [CNT_W-1:0]             cmd_idx,
   input  logic                         cmd_flush,
   input  logic                         cmd_rewind,
   input  logic                         busy,
   input  logic [CH_W-1:0]              cur_ch,
   input  logic                         s1_v,
   input  logic                         sch_hs,
   input  logic [NUM_CH-1:0][CNT_W-1:0] cnt_all,
   input  logic [NUM_CH-1:0][CNT_W-1:0] pos_all,
   output logic                         cmd_ready,
   output logic                         cmd_err,
   output logic [NUM_CH-1:0]            drop,
   output logic [NUM_CH-1:0]            rew,
   output logic                         rdy_nxt
);

   pkq_op_e          op;
   logic             want_f;
   logic             want_r;
   logic             sel_ok;
   logic             on_cur;
   logic             defer;
   logic             hs;
   logic             bad;
   logic [CNT_W-1:0] c_cnt;
   logic [CNT_W-1:0] c_pos;

   assign op     = pkq_op_e'({cmd_rewind, cmd_flush});
   assign sel_ok = int'(cmd_ch) < NUM_CH;
   assign on_cur = busy && (cmd_ch == cur_ch);
   assign hs     = cmd_valid && cmd_ready;

   always_comb begin
      unique case (op)
         OP_FLUSH:  begin want_f = 1'b1; want_r = 1'b0; end
         OP_REWIND: begin want_f = 1'b0; want_r = 1'b1; end
         OP_BOTH:   begin want_f = 1'b1; want_r = 1'b1; end
         default:   begin want_f = 1'b0; want_r = 1'b0; end
      endcase
   end

   always_comb begin
      c_cnt = '0;
      c_pos = '0;
      if (sel_ok) begin
         c_cnt = cnt_all[cmd_ch];
         c_pos = pos_all[cmd_ch];
      end
   end

   assign defer   = want_r && on_cur;
   assign rdy_nxt = cmd_valid && !cmd_ready && !defer && !s1_v && !sch_hs;

   always_comb begin
      bad = !sel_ok;
      if (want_f && ((cmd_idx == '0) || (cmd_idx > c_cnt) || (on_cur && (cmd_idx >= c_pos))))
         bad = 1'b1;
      if (want_r && (cmd_idx >= c_cnt))
         bad = 1'b1;
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_apply
      logic hit;
      assign hit     = hs && !bad && (cmd_ch == CH_W'(c));
      assign drop[c] = hit && want_f;
      assign rew[c]  = hit && want_r;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_ready <= 1'b0;
         cmd_err   <= 1'b0;
      end else begin
         cmd_ready <= rdy_nxt;
         cmd_err   <= hs && bad;
      end
   end

endmodule

// File: rtl/pkq_query.sv
// One-cycle registered status lookup.
module pkq_query #(
   parameter int NUM_CH = 4,
   parameter int CH_W   = 2,
   parameter int CNT_W  = 4
)(
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [CH_W-1:0]              qry_ch,
   input  logic [NUM_CH-1:0][CNT_W-1:0] cnt_all,
   input  logic [NUM_CH-1:0][CNT_W-1:0] pos_all,
   output logic [CH_W-1:0]              qry_ch_echo,
   output logic [CNT_W-1:0]             qry_cnt,
   output logic [CNT_W-1:0]             qry_pos
);

   logic ok;
   assign ok = int'(qry_ch) < NUM_CH;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         qry_ch_echo <= '0;
         qry_cnt     <= '0;
         qry_pos     <= '0;
      end else begin
         qry_ch_echo <= qry_ch;
         qry_cnt     <= ok ? cnt_all[qry_ch] : '0;
         qry_pos     <= ok ? pos_all[qry_ch] : '0;
      end
   end

endmodule

// File: rtl/pkt_replay_mgr.sv
module pkt_replay_mgr #(
   parameter  int NUM_CH = 4,
   parameter  int DEPTH  = 8,
   parameter  int ADDR_W = 12,
   parameter  int LEN_W  = 14,
   localparam int CH_W   = pkq_pkg::bits_for(NUM_CH),
   localparam int PTR_W  = pkq_pkg::bits_for(DEPTH),
   localparam int CNT_W  = $clog2(DEPTH + 1),
   localparam int DESC_W = ADDR_W + LEN_W
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_commit,
   input  logic [CH_W-1:0]   wr_ch,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [LEN_W-1:0]  wr_len,
   input  logic              rd_done,
   input  logic              sch_valid,
   input  logic [CH_W-1:0]   sch_ch,
   output logic              sch_ready,
   output logic              sch_ack,
   output logic [CH_W-1:0]   out_ch,
   output logic [ADDR_W-1:0] out_addr,
   output logic [LEN_W-1:0]  out_len,
   output logic [NUM_CH-1:0] rd_avail,
   input  logic              cmd_valid,
   input  logic [CH_W-1:0]   cmd_ch,
   input  logic [CNT_W-1:0]  cmd_idx,
   input  logic              cmd_flush,
   input  logic              cmd_rewind,
   output logic              cmd_ready,
   output logic              cmd_err,
   input  logic [CH_W-1:0]   qry_ch,
   output logic [CH_W-1:0]   qry_ch_echo,
   output logic [CNT_W-1:0]  qry_cnt,
   output logic [CNT_W-1:0]  qry_pos
);

   if (NUM_CH < 1) begin : g_bad_ch
      $error("pkt_replay_mgr: NUM_CH must be at least 1");
   end
   if ((DEPTH < 2) || ((DEPTH & (DEPTH - 1)) != 0)) begin : g_bad_depth
      $error("pkt_replay_mgr: DEPTH must be a power of two, 2 or more");
   end
   if ((ADDR_W < 1) || (LEN_W < 1)) begin : g_bad_w
      $error("pkt_replay_mgr: descriptor fields need a width");
   end

   logic [NUM_CH-1:0][CNT_W-1:0]  cnt_all;
   logic [NUM_CH-1:0][CNT_W-1:0]  pos_all;
   logic [NUM_CH-1:0][DESC_W-1:0] desc_all;
   logic [NUM_CH-1:0]             adv;
   logic [NUM_CH-1:0]             drop;
   logic [NUM_CH-1:0]             rew;
   logic [DESC_W-1:0]             out_desc;
   logic [DESC_W-1:0]             in_desc;
   logic                          busy;
   logic [CH_W-1:0]               cur_ch;
   logic                          s1_v;
   logic                          sch_hs;
   logic                          cmd_rdy_nxt;

   assign in_desc = {wr_addr, wr_len};

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      pkq_ring #(
         .DEPTH (DEPTH),
         .DESC_W(DESC_W),
         .PTR_W (PTR_W),
         .CNT_W (CNT_W)
      ) u_ring (
         .clk      (clk),
         .rst_n    (rst_n),
         .push     (wr_commit && (wr_ch == CH_W'(c))),
         .push_desc(in_desc),
         .adv      (adv[c]),
         .drop     (drop[c]),
         .rewind   (rew[c]),
         .amount   (cmd_idx),
         .count    (cnt_all[c]),
         .pos      (pos_all[c]),
         .next_desc(desc_all[c])
      );
      assign rd_avail[c] = cnt_all[c] != '0;
   end

   pkq_sched #(
      .NUM_CH(NUM_CH),
      .CH_W  (CH_W),
      .CNT_W (CNT_W),
      .DESC_W(DESC_W)
   ) u_sched (
      .clk      (clk),
      .rst_n    (rst_n),
      .sch_valid(sch_valid),
      .sch_ch   (sch_ch),
      .block_i  (cmd_rdy_nxt),
      .done_i   (rd_done),
      .cnt_all  (cnt_all),
      .pos_all  (pos_all),
      .desc_all (desc_all),
      .sch_ready(sch_ready),
      .sch_ack  (sch_ack),
      .out_ch   (out_ch),
      .out_desc (out_desc),
      .adv      (adv),
      .busy     (busy),
      .cur_ch   (cur_ch),
      .s1_v     (s1_v),
      .sch_hs   (sch_hs)
   );

   pkq_cmd #(
      .NUM_CH(NUM_CH),
      .CH_W  (CH_W),
      .CNT_W (CNT_W)
   ) u_cmd (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (cmd_valid),
      .cmd_ch    (cmd_ch),
      .cmd_idx   (cmd_idx),
      .cmd_flush (cmd_flush),
      .cmd_rewind(cmd_rewind),
      .busy      (busy),
      .cur_ch    (cur_ch),
      .s1_v      (s1_v),
      .sch_hs    (sch_hs),
      .cnt_all   (cnt_all),
      .pos_all   (pos_all),
      .cmd_ready (cmd_ready),
      .cmd_err   (cmd_err),
      .drop      (drop),
      .rew       (rew),
      .rdy_nxt   (cmd_rdy_nxt)
   );

   pkq_query #(
      .NUM_CH(NUM_CH),
      .CH_W  (CH_W),
      .CNT_W (CNT_W)
   ) u_query (
      .clk        (clk),
      .rst_n      (rst_n),
      .qry_ch     (qry_ch),
      .cnt_all    (cnt_all),
      .pos_all    (pos_all),
      .qry_ch_echo(qry_ch_echo),
      .qry_cnt    (qry_cnt),
      .qry_pos    (qry_pos)
   );

   assign out_addr = out_desc[DESC_W-1:LEN_W];
   assign out_len  = out_desc[LEN_W-1:0];

endmodule

// File: rtl/pkt_replay_mgr_chk.sv
module pkt_replay_mgr_chk #(
   parameter int CNT_W = 4
)(
   input logic             clk,
   input logic             rst_n,
   input logic             sch_valid,
   input logic             sch_ready,
   input logic             sch_ack,
   input logic             cmd_valid,
   input logic             cmd_ready,
   input logic             cmd_err,
   input logic [CNT_W-1:0] qry_cnt,
   input logic [CNT_W-1:0] qry_pos
);

   // R4
   sch_rdy_after_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sch_ready |-> $past(sch_valid));

   // R4
   rdy_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(sch_ready && cmd_ready));

   // R5
   ack_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sch_ack |-> $past(sch_valid && sch_ready, 2));

   // R5
   ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sch_ack |=> !sch_ack);

   // R10
   cmd_rdy_after_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_ready |-> $past(cmd_valid));

   // R10
   cmd_rdy_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_ready |=> !cmd_ready);

   // R12
   err_after_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_err |-> $past(cmd_valid && cmd_ready));

   // R7
   pos_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      qry_pos <= qry_cnt);

endmodule

bind pkt_replay_mgr pkt_replay_mgr_chk #(.CNT_W(CNT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .sch_valid(sch_valid),
   .sch_ready(sch_ready),
   .sch_ack  (sch_ack),
   .cmd_valid(cmd_valid),
   .cmd_ready(cmd_ready),
   .cmd_err  (cmd_err),
   .qry_cnt  (qry_cnt),
   .qry_pos  (qry_pos)
);

// File: tb/sim_pkt_replay_mgr.sv
`timescale 1ns/1ps
module sim_pkt_replay_mgr;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        wr_commit;
   logic [1:0]  wr_ch;
   logic [11:0] wr_addr;
   logic [13:0] wr_len;
   logic        rd_done;
   logic        sch_valid;
   logic [1:0]  sch_ch;
   logic        sch_ready;
   logic        sch_ack;
   logic [1:0]  out_ch;
   logic [11:0] out_addr;
   logic [13:0] out_len;
   logic [3:0]  rd_avail;
   logic        cmd_valid;
   logic [1:0]  cmd_ch;
   logic [3:0]  cmd_idx;
   logic        cmd_flush;
   logic        cmd_rewind;
   logic        cmd_ready;
   logic        cmd_err;
   logic [1:0]  qry_ch;
   logic [1:0]  qry_ch_echo;
   logic [3:0]  qry_cnt;
   logic [3:0]  qry_pos;

   always #10 clk = ~clk;

   pkt_replay_mgr u0 (
      .clk(clk), .rst_n(rst_n),
      .wr_commit(wr_commit), .wr_ch(wr_ch), .wr_addr(wr_addr), .wr_len(wr_len),
      .rd_done(rd_done),
      .sch_valid(sch_valid), .sch_ch(sch_ch), .sch_ready(sch_ready), .sch_ack(sch_ack),
      .out_ch(out_ch), .out_addr(out_addr), .out_len(out_len),
      .rd_avail(rd_avail),
      .cmd_valid(cmd_valid), .cmd_ch(cmd_ch), .cmd_idx(cmd_idx),
      .cmd_flush(cmd_flush), .cmd_rewind(cmd_rewind), .cmd_ready(cmd_ready), .cmd_err(cmd_err),
      .qry_ch(qry_ch), .qry_ch_echo(qry_ch_echo), .qry_cnt(qry_cnt), .qry_pos(qry_pos)
   );

   int n_cmp = 0;
   int n_bad = 0;
   int seq   = 0;

   int          m_cnt [4];
   int          m_pos [4];
   logic [11:0] m_addr [4][8];
   logic [13:0] m_len  [4][8];
   bit          m_busy = 0;
   int          m_cur  = 0;

   task automatic chk(input string req, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic do_commit(input int ch);
      @(negedge clk);
      wr_commit = 1'b1;
      wr_ch     = 2'(ch);
      wr_addr   = 12'(ch * 256 + (seq % 256));
      wr_len    = 14'(64 + seq * 3);
      if (m_cnt[ch] < 8) begin
         m_addr[ch][m_cnt[ch]] = wr_addr;
         m_len[ch][m_cnt[ch]]  = wr_len;
         m_cnt[ch]++;
      end
      seq++;
      @(negedge clk);
      wr_commit = 1'b0;
   endtask

   task automatic do_query(input int ch, input string req);
      @(negedge clk);
      qry_ch = 2'(ch);
      @(negedge clk);
      chk(req, int'(qry_ch_echo), ch);
      chk(req, int'(qry_cnt), m_cnt[ch]);
      chk(req, int'(qry_pos), m_pos[ch]);
      chk({req, " R2 avail"}, int'(rd_avail[ch]), int'(m_cnt[ch] != 0));
   endtask

   task automatic do_done();
      @(negedge clk);
      rd_done = 1'b1;
      @(negedge clk);
      rd_done = 1'b0;
      m_busy = 0;
   endtask

   task automatic do_sched(input int ch, input string req);
      int  w;
      bit  hit;
      hit = !m_busy && (m_pos[ch] < m_cnt[ch]);
      @(negedge clk);
      sch_valid = 1'b1;
      sch_ch    = 2'(ch);
      w = 0;
      do begin
         @(negedge clk);
         w++;
      end while (!sch_ready && w < 40);
      if (!sch_ready) begin
         chk({req, " R4 sched timeout"}, 0, 1);
         sch_valid = 1'b0;
         return;
      end
      @(negedge clk);
      sch_valid = 1'b0;
      chk({req, " R5 no early ack"}, int'(sch_ack), 0);
      @(negedge clk);
      chk({req, " R5 ack"}, int'(sch_ack), int'(hit));
      if (hit) begin
         chk({req, " R5 ch"}, int'(out_ch), ch);
         chk({req, " R5 addr"}, int'(out_addr), int'(m_addr[ch][m_pos[ch]]));
         chk({req, " R5 len"}, int'(out_len), int'(m_len[ch][m_pos[ch]]));
         m_pos[ch]++;
         m_busy = 1;
         m_cur  = ch;
      end
   endtask

   task automatic do_cmd(input int ch, input int n, input bit f, input bit r,
                         input int hold, input string req);
      int w;
      bit bad;
      int base;
      @(negedge clk);
      cmd_valid  = 1'b1;
      cmd_ch     = 2'(ch);
      cmd_idx    = 4'(n);
      cmd_flush  = f;
      cmd_rewind = r;
      if (hold > 0) begin
         for (int k = 0; k < hold; k++) begin
            @(negedge clk);
            chk("R11 deferred", int'(cmd_ready), 0);
         end
         rd_done = 1'b1;
         @(negedge clk);
         rd_done = 1'b0;
         m_busy = 0;
         chk("R11 still deferred at done", int'(cmd_ready), 0);
      end
      bad = (f && (n == 0 || n > m_cnt[ch] || (m_busy && m_cur == ch && n >= m_pos[ch])))
            || (r && n >= m_cnt[ch]);
      w = 0;
      do begin
         @(negedge clk);
         w++;
      end while (!cmd_ready && w < 40);
      if (!cmd_ready) begin
         chk({req, " R10 cmd timeout"}, 0, 1);
         cmd_valid = 1'b0;
         return;
      end
      @(negedge clk);
      cmd_valid = 1'b0;
      chk({req, " R12 err"}, int'(cmd_err), int'(bad));
      if (!bad) begin
         base = r ? n : m_pos[ch];
         if (f) begin
            for (int i = 0; i < 8; i++) begin
               if (i + n < 8) begin
                  m_addr[ch][i] = m_addr[ch][i + n];
                  m_len[ch][i]  = m_len[ch][i + n];
               end
            end
            m_cnt[ch] -= n;
            base = (base >= n) ? base - n : 0;
         end
         m_pos[ch] = base;
      end
      @(negedge clk);
      chk({req, " R12 err pulse"}, int'(cmd_err), 0);
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
      $finish;
   end

   initial begin
      for (int c = 0; c < 4; c++) begin
         m_cnt[c] = 0;
         m_pos[c] = 0;
      end
      rst_n = 1'b0; wr_commit = 1'b0; wr_ch = '0; wr_addr = '0; wr_len = '0;
      rd_done = 1'b0; sch_valid = 1'b0; sch_ch = '0; cmd_valid = 1'b0; cmd_ch = '0;
      cmd_idx = '0; cmd_flush = 1'b0; cmd_rewind = 1'b0; qry_ch = '0;
      repeat (3) @(negedge clk);
      chk("R2 reset avail", int'(rd_avail), 0);
      chk("R4 reset sch_ready", int'(sch_ready), 0);
      chk("R5 reset ack", int'(sch_ack), 0);
      chk("R10 reset cmd_ready", int'(cmd_ready), 0);
      chk("R12 reset err", int'(cmd_err), 0);
      rst_n = 1'b1;
      for (int c = 0; c < 4; c++) do_query(c, "R3 empty");

      // R1: fill channels, including an overflow commit on channel 2
      for (int i = 0; i < 3; i++) do_commit(0);
      do_commit(1);
      for (int i = 0; i < 9; i++) do_commit(2);
      for (int c = 0; c < 4; c++) do_query(c, "R1 counts");

      // R5: empty channel gives no ack; stored ones issue in order
      do_sched(3, "R5 empty");
      do_sched(0, "R5 first");
      // R4: no acceptance while a packet is in flight
      @(negedge clk);
      sch_valid = 1'b1;
      sch_ch    = 2'd1;
      for (int k = 0; k < 5; k++) begin
         @(negedge clk);
         chk("R4 busy holds ready", int'(sch_ready), 0);
      end
      sch_valid = 1'b0;
      do_done();
      do_sched(0, "R5 second");
      do_done();
      do_sched(1, "R5 ch1");
      do_done();
      do_sched(1, "R5 twice");
      do_query(1, "R6 kept");

      // R8: replay via rewind
      do_cmd(1, 0, 0, 1, 0, "R8 rewind0");
      do_query(1, "R8 pos");
      do_sched(1, "R8 replay");
      do_done();

      // R7: flush oldest
      do_cmd(0, 1, 1, 0, 0, "R7 flush1");
      do_query(0, "R7 after");

      // R12: illegal commands leave state alone
      do_cmd(0, 0, 1, 0, 0, "R12 flush0");
      do_cmd(0, 3, 1, 0, 0, "R12 flush>cnt");
      do_cmd(0, 2, 0, 1, 0, "R12 rewind>=cnt");
      do_query(0, "R12 unchanged");

      // R13: no-op command
      do_cmd(0, 1, 0, 0, 0, "R13 noop");
      do_query(0, "R13 unchanged");

      // R12 / R11: in-flight packet protection and rewind deferral
      do_sched(2, "R5 ch2");
      do_cmd(2, 1, 1, 0, 0, "R12 flush current");
      do_cmd(2, 3, 0, 1, 6, "R11 rewind");
      do_query(2, "R11 pos");

      // R9: combined flush and rewind
      do_cmd(2, 2, 1, 1, 0, "R9 both");
      do_query(2, "R9 after");
      do_sched(2, "R9 next");
      do_done();

      // R8 sweep of every index on channel 2
      for (int n = 0; n <= 8; n++) begin
         do_cmd(2, n, 0, 1, 0, "R8 sweep");
         do_query(2, "R8 sweep q");
      end

      // R7 / R9 sweep, then refill across the ring wrap and drain
      do_cmd(2, 2, 1, 0, 0, "R7 sweep");
      do_query(2, "R7 sweep q");
      do_cmd(2, 1, 1, 1, 0, "R9 sweep");
      do_query(2, "R9 sweep q");
      for (int i = 0; i < 6; i++) do_commit(2);
      do_query(2, "R1 wrap");
      do_cmd(2, 0, 0, 1, 0, "R8 to oldest");
      for (int i = 0; i < 8; i++) begin
         do_sched(2, "R6 drain");
         do_done();
      end
      do_sched(2, "R5 drained");
      do_cmd(2, 8, 1, 0, 0, "R7 flush all");
      do_query(2, "R7 empty");

      summary();
      $finish;
   end

endmodule